// File: doc/BRIEF.md
# Interrupt Pending and Priority Selector

This block keeps the per-interrupt state of a set of shared peripheral interrupts and picks, for a single CPU, the one interrupt that should be signalled next. For every interrupt it stores an enable flag, a trigger type (edge or level), an 8-bit priority, a latched pending flag and the last sampled level of the input line. From this state it forms an effective pending vector. It then scans the interrupts in ascending order and presents the enabled, effectively pending interrupt with the numerically lowest priority.

Software-side logic drives single-cycle configuration writes, acknowledge strobes and end-of-interrupt strobes, each carrying an interrupt ID. A mode input selects between two pending models. In the legacy model a level interrupt is pending only through its latch, and the latch is refilled at end-of-interrupt while the line is still high. In the newer model a level interrupt counts as pending for as long as its line is high, and the latch only records edges and explicit software requests. A byte-wide readback returns the effective pending bits of eight consecutive interrupts.

Top module: `irq_prio_select`

## Requirements
- R1: When no interrupt is both enabled and effectively pending, `sel_id` is 1023 and `sel_prio` is 0xFF; this is also the value after reset.
- R2: Among the candidates, the one with the lowest numeric priority is selected. When priorities are equal, the lowest interrupt number wins.
- R3: An interrupt is a candidate only when its enable bit is set and it is effectively pending. A latched interrupt that is disabled is never selected.
- R4: The stored level of each line takes the line value every cycle. A latch event happens only on a 0-to-1 change of the stored level, so a line held high produces no further latching after an acknowledge.
- R5: In legacy mode (`mode_newer`=0), a rising line sets the latch if the interrupt is edge-triggered or enabled. A rising line on a disabled level interrupt latches nothing.
- R6: In newer mode (`mode_newer`=1), a rising line sets the latch only for an edge-triggered interrupt. A level interrupt is effectively pending while its stored level is high or its latch is set.
- R7: An acknowledge for an ID clears that interrupt's latch for both trigger types. In newer mode, a level interrupt whose line is still high stays effectively pending.
- R8: In legacy mode, an end-of-interrupt for an enabled level interrupt whose stored level is high sets its latch again.
- R9: In newer mode, an end-of-interrupt sets no latch. A level interrupt stops being pending once its line falls.
- R10: `rd_pend_byte` returns the effective pending bits of interrupts 8*`rd_byte_idx` to 8*`rd_byte_idx`+7, where bit i stands for interrupt 8*`rd_byte_idx`+i.
- R11: `sel_id` and `sel_prio` are registered. They show the selection for the state present after the previous clock edge, so a state change made at edge k appears on them after edge k+1.
- R12: A configuration write applies to the interrupt `cfg_id`, with `cfg_field` encoded as 0 = enable (`cfg_data[0]`), 1 = trigger (`cfg_data[0]`, 1 = edge), 2 = priority (`cfg_data`), 3 = set latch, 4 = clear latch. A latch set and a latch clear in the same cycle leave the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_newer | input | 1 | 0 = legacy pending model, 1 = newer pending model |
| irq_lines | input | 64 | Interrupt input lines, one per interrupt |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 3 | Field selector for the write (see R12) |
| cfg_id | input | 10 | Interrupt ID targeted by the write |
| cfg_data | input | 8 | Write data |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 10 | Acknowledged interrupt ID |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | Completed interrupt ID |
| rd_byte_idx | input | 3 | Byte index for the pending readback |
| rd_pend_byte | output | 8 | Effective pending bits of eight interrupts |
| sel_id | output | 10 | Selected interrupt ID, 1023 when none |
| sel_prio | output | 8 | Priority of the selected interrupt, 0xFF when none |

## Verification
A corrupted latch, level or enable bit appears at the ports within two clock edges of the stimulus that exposes it. The readback shows it after one edge and `sel_id` after two, because the selection adds one register stage. A wrong pending model shows up as an interrupt that stays selected after its line falls, or one that never appears while its line is high. A wrong scan order shows up only when priorities tie, so the bench sets up equal priorities on purpose, then changes one of them and checks that the winner moves.

// File: rtl/irq_sel_pkg.sv
// Package: shared encodings for the interrupt pending/priority selector.
// Assumes IDs are 10 bits wide, with 1023 reserved for "nothing selected".
package irq_sel_pkg;

    localparam int unsigned ID_W = 10;
    localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;

    // Field selector for configuration writes
    typedef enum logic [2:0] {
        CF_ENABLE   = 3'd0,
        CF_TRIGGER  = 3'd1,
        CF_PRIORITY = 3'd2,
        CF_SET_PEND = 3'd3,
        CF_CLR_PEND = 3'd4
    } cfg_field_e;

endpackage

// File: rtl/irq_state_bank.sv
// Module: irq_state_bank
// Holds the enable, trigger, priority, stored level and pending latch of every
// interrupt. It applies line changes, configuration writes, acknowledges and
// end-of-interrupts, and derives the effective pending and candidate vectors
// for the current mode.
// Assumes NUM_IRQ is a power of two no larger than 1023, and single-cycle strobes.
module irq_state_bank
    import irq_sel_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned PRIO_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_newer,
    input  logic [NUM_IRQ-1:0]        irq_lines,
    input  logic                      cfg_we,
    input  logic [2:0]                cfg_field,
    input  logic [ID_W-1:0]           cfg_id,
    input  logic [PRIO_W-1:0]         cfg_data,
    input  logic                      ack_valid,
    input  logic [ID_W-1:0]           ack_id,
    input  logic                      eoi_valid,
    input  logic [ID_W-1:0]           eoi_id,
    output logic [NUM_IRQ-1:0]        eff_pend_o,
    output logic [NUM_IRQ-1:0]        cand_o,
    output logic [NUM_IRQ*PRIO_W-1:0] prio_flat_o
);

    localparam int unsigned IDX_W = $clog2(NUM_IRQ);

    logic [NUM_IRQ-1:0] en_q, edge_q, lvl_q, pend_q;
    logic [PRIO_W-1:0]  prio_q [NUM_IRQ];

    logic [NUM_IRQ-1:0] cfg_hit, ack_hit, eoi_hit;
    logic [NUM_IRQ-1:0] rise, set_vec, clr_vec;
    logic [NUM_IRQ-1:0] legacy_m, set_pend_m, clr_pend_m;
    cfg_field_e         fld;

    assign fld = cfg_field_e'(cfg_field);

    // Per-interrupt ID decode of the three strobes, and priority flattening
    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_dec
        assign cfg_hit[gi] = cfg_we    && (cfg_id == ID_W'(gi));
        assign ack_hit[gi] = ack_valid && (ack_id == ID_W'(gi));
        assign eoi_hit[gi] = eoi_valid && (eoi_id == ID_W'(gi));
        assign prio_flat_o[gi*PRIO_W +: PRIO_W] = prio_q[gi];
    end

    // Latch set and clear terms for the current mode
    always_comb begin
        legacy_m   = {NUM_IRQ{~mode_newer}};
        set_pend_m = {NUM_IRQ{fld == CF_SET_PEND}};
        clr_pend_m = {NUM_IRQ{fld == CF_CLR_PEND}};
        rise       = irq_lines & ~lvl_q;
        set_vec    = (rise & (edge_q | (legacy_m & en_q)))
                   | (eoi_hit & legacy_m & ~edge_q & en_q & lvl_q)
                   | (cfg_hit & set_pend_m);
        clr_vec    = ack_hit | (cfg_hit & clr_pend_m);
    end

    // State registers: level sampling, pending latch, configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            edge_q <= '0;
            lvl_q  <= '0;
            pend_q <= '0;
            for (int i = 0; i < NUM_IRQ; i++) begin
                prio_q[i] <= '0;
            end
        end else begin
            lvl_q  <= irq_lines;
            pend_q <= (pend_q & ~clr_vec) | set_vec;
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (cfg_hit[i]) begin
                    case (fld)
                        CF_ENABLE:   en_q[i]   <= cfg_data[0];
                        CF_TRIGGER:  edge_q[i] <= cfg_data[0];
                        CF_PRIORITY: prio_q[i] <= cfg_data;
                        default: ;
                    endcase
                end
            end
        end
    end

    // Effective pending per mode, and the candidate set for the selector
    always_comb begin
        eff_pend_o = mode_newer ? (pend_q | (~edge_q & lvl_q)) : pend_q;
        cand_o     = en_q & eff_pend_o;
    end

    AST_LVL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (lvl_q == $past(irq_lines))); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && (ack_id < ID_W'(NUM_IRQ)) && !set_vec[ack_id[IDX_W-1:0]])
        |=> !pend_q[$past(ack_id[IDX_W-1:0])]); // R7

endmodule

// File: rtl/irq_best_pick.sv
// Module: irq_best_pick
// Scans the candidates in ascending order and keeps the strictly lower
// priority, so the lowest number wins a tie. It registers the winning ID and
// priority. Assumes PRIO_W-bit priorities; "none" is reported as NO_IRQ / all ones.
module irq_best_pick
    import irq_sel_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned PRIO_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        cand_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat_i,
    output logic [ID_W-1:0]           sel_id_o,
    output logic [PRIO_W-1:0]         sel_prio_o
);

    localparam int unsigned IDX_W = $clog2(NUM_IRQ);

    logic [PRIO_W:0]   best_p;
    logic [ID_W-1:0]   best_i;
    logic [PRIO_W-1:0] cur_p;

    // Ascending linear scan with a sentinel one above the largest priority
    always_comb begin
        best_p = {1'b1, {PRIO_W{1'b0}}};
        best_i = NO_IRQ;
        cur_p  = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            cur_p = prio_flat_i[i*PRIO_W +: PRIO_W];
            if (cand_i[i] && ({1'b0, cur_p} < best_p)) begin
                best_p = {1'b0, cur_p};
                best_i = ID_W'(i);
            end
        end
    end

    // Output register for the winner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_id_o   <= NO_IRQ;
            sel_prio_o <= '1;
        end else begin
            sel_id_o   <= best_i;
            sel_prio_o <= best_p[PRIO_W] ? {PRIO_W{1'b1}} : best_p[PRIO_W-1:0];
        end
    end

    AST_IDLE_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (cand_i == '0)) |=> (sel_id_o == NO_IRQ)); // R1

    AST_WINNER_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_id_o != NO_IRQ) |->
        (|($past(cand_i) & (NUM_IRQ'(1) << sel_id_o[IDX_W-1:0])))); // R3

endmodule

// File: rtl/irq_pend_readback.sv
// Module: irq_pend_readback
// Groups the effective pending vector into bytes and returns the byte picked by
// the index. Bit i of a byte is interrupt 8*index+i.
// Assumes NUM_IRQ is a multiple of 8.
module irq_pend_readback #(
    parameter int unsigned NUM_IRQ = 64,
    localparam int unsigned NUM_BYTES  = NUM_IRQ / 8,
    localparam int unsigned BYTE_IDX_W = $clog2(NUM_BYTES)
) (
    input  logic [NUM_IRQ-1:0]    pend_i,
    input  logic [BYTE_IDX_W-1:0] byte_idx_i,
    output logic [7:0]            byte_o
);

    logic [7:0] bytes [NUM_BYTES];

    // Slice the pending vector into byte lanes
    for (genvar gb = 0; gb < NUM_BYTES; gb++) begin : g_lane
        assign bytes[gb] = pend_i[gb*8 +: 8];
    end

    // Byte multiplexer
    assign byte_o = bytes[byte_idx_i];

endmodule

// File: rtl/irq_prio_select.sv
// Module: irq_prio_select (top)
// Interrupt pending and priority selector for one CPU. It connects the state
// bank, the selector and the pending readback.
// Assumes the 64-interrupt default and that all strobes come from the clk domain.
module irq_prio_select
    import irq_sel_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned PRIO_W  = 8,
    localparam int unsigned BYTE_IDX_W = $clog2(NUM_IRQ / 8)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_newer,
    input  logic [NUM_IRQ-1:0]    irq_lines,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_field,
    input  logic [9:0]            cfg_id,
    input  logic [PRIO_W-1:0]     cfg_data,
    input  logic                  ack_valid,
    input  logic [9:0]            ack_id,
    input  logic                  eoi_valid,
    input  logic [9:0]            eoi_id,
    input  logic [BYTE_IDX_W-1:0] rd_byte_idx,
    output logic [7:0]            rd_pend_byte,
    output logic [9:0]            sel_id,
    output logic [PRIO_W-1:0]     sel_prio
);

    logic [NUM_IRQ-1:0]        eff_pend;
    logic [NUM_IRQ-1:0]        cand;
    logic [NUM_IRQ*PRIO_W-1:0] prio_flat;

    irq_state_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_newer  (mode_newer),
        .irq_lines   (irq_lines),
        .cfg_we      (cfg_we),
        .cfg_field   (cfg_field),
        .cfg_id      (cfg_id),
        .cfg_data    (cfg_data),
        .ack_valid   (ack_valid),
        .ack_id      (ack_id),
        .eoi_valid   (eoi_valid),
        .eoi_id      (eoi_id),
        .eff_pend_o  (eff_pend),
        .cand_o      (cand),
        .prio_flat_o (prio_flat)
    );

    irq_best_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .cand_i      (cand),
        .prio_flat_i (prio_flat),
        .sel_id_o    (sel_id),
        .sel_prio_o  (sel_prio)
    );

    irq_pend_readback #(.NUM_IRQ(NUM_IRQ)) u_rdbk (
        .pend_i     (eff_pend),
        .byte_idx_i (rd_byte_idx),
        .byte_o     (rd_pend_byte)
    );

endmodule

// File: tb/sim_irq_prio_select.sv
`timescale 1ns/1ps
module sim_irq_prio_select;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_newer = 1'b0;
    logic [63:0] irq_lines = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_field = '0;
    logic [9:0]  cfg_id = '0;
    logic [7:0]  cfg_data = '0;
    logic        ack_valid = 1'b0;
    logic [9:0]  ack_id = '0;
    logic        eoi_valid = 1'b0;
    logic [9:0]  eoi_id = '0;
    logic [2:0]  rd_byte_idx = '0;
    logic [7:0]  rd_pend_byte;
    logic [9:0]  sel_id;
    logic [7:0]  sel_prio;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [9:0] id;
        logic [7:0] prio;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    irq_prio_select u0 (
        .clk(clk), .rst_n(rst_n), .mode_newer(mode_newer), .irq_lines(irq_lines),
        .cfg_we(cfg_we), .cfg_field(cfg_field), .cfg_id(cfg_id), .cfg_data(cfg_data),
        .ack_valid(ack_valid), .ack_id(ack_id), .eoi_valid(eoi_valid), .eoi_id(eoi_id),
        .rd_byte_idx(rd_byte_idx), .rd_pend_byte(rd_pend_byte),
        .sel_id(sel_id), .sel_prio(sel_prio)
    );

    // Monitor: pops expected selections and compares them with the outputs
    initial begin
        forever begin
            wait (exp_q.size() != 0);
            #1;
            begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (sel_id !== e.id || sel_prio !== e.prio) begin
                    failures++;
                    $display("FAIL %s: sel_id=%0d sel_prio=%0h expected id=%0d prio=%0h",
                             e.tag, sel_id, sel_prio, e.id, e.prio);
                end
            end
        end
    end

    // Driver side: push an expected item and wait until the monitor consumes it
    task automatic expect_sel(input logic [9:0] id, input logic [7:0] prio, input string tag);
        exp_t e;
        e.id = id; e.prio = prio; e.tag = tag;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    task automatic expect_rd(input logic [2:0] idx, input logic [7:0] exp_b, input string tag);
        rd_byte_idx = idx;
        #0.5;
        checks++;
        if (rd_pend_byte !== exp_b) begin
            failures++;
            $display("FAIL %s: rd_pend_byte=%0h expected %0h", tag, rd_pend_byte, exp_b);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic cfg_wr(input logic [2:0] f, input int id, input logic [7:0] d);
        cfg_we = 1'b1; cfg_field = f; cfg_id = 10'(id); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_ack(input int id);
        ack_valid = 1'b1; ack_id = 10'(id);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic do_eoi(input int id);
        eoi_valid = 1'b1; eoi_id = 10'(id);
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        expect_sel(10'd1023, 8'hFF, "R1 reset state");
        expect_rd(3'd0, 8'h00, "R10 reset readback");

        // Legacy: disabled level interrupt does not latch on a rising line
        irq_lines[5] = 1'b1; step(2);
        expect_sel(10'd1023, 8'hFF, "R5 disabled level no latch");
        expect_rd(3'd0, 8'h00, "R5 readback no latch");
        irq_lines[5] = 1'b0; step(1);

        // Edge interrupt latches while disabled but is not selected
        cfg_wr(3'd2, 5, 8'h40);
        cfg_wr(3'd1, 5, 8'h01);
        irq_lines[5] = 1'b1; step(2);
        expect_sel(10'd1023, 8'hFF, "R3 latched but disabled");
        expect_rd(3'd0, 8'h20, "R10 byte0 bit5");
        cfg_wr(3'd0, 5, 8'h01);
        expect_sel(10'd1023, 8'hFF, "R11 one cycle after enable");
        step(1);
        expect_sel(10'd5, 8'h40, "R12 enable selects");

        // Tie on priority, then lower priority wins
        cfg_wr(3'd2, 9, 8'h40);
        cfg_wr(3'd1, 9, 8'h01);
        cfg_wr(3'd0, 9, 8'h01);
        irq_lines[9] = 1'b1; step(2);
        expect_sel(10'd5, 8'h40, "R2 tie lowest id");
        cfg_wr(3'd2, 9, 8'h10); step(1);
        expect_sel(10'd9, 8'h10, "R2 lower value wins");

        // Acknowledge clears edge latches
        do_ack(9); step(1);
        expect_sel(10'd5, 8'h40, "R7 ack clears edge");
        do_ack(5); step(1);
        expect_sel(10'd1023, 8'hFF, "R7 ack clears second");
        irq_lines[5] = 1'b0; irq_lines[9] = 1'b0; step(1);

        // Held-high line does not re-latch
        cfg_wr(3'd2, 12, 8'h20);
        cfg_wr(3'd1, 12, 8'h01);
        cfg_wr(3'd0, 12, 8'h01);
        irq_lines[12] = 1'b1; step(2);
        expect_sel(10'd12, 8'h20, "R4 edge latch");
        do_ack(12); step(1);
        expect_sel(10'd1023, 8'hFF, "R4 ack");
        step(3);
        expect_sel(10'd1023, 8'hFF, "R4 held line no relatch");
        irq_lines[12] = 1'b0; step(1);

        // Legacy level interrupt and end-of-interrupt refill
        cfg_wr(3'd2, 20, 8'h30);
        cfg_wr(3'd0, 20, 8'h01);
        irq_lines[20] = 1'b1; step(2);
        expect_sel(10'd20, 8'h30, "R5 enabled level latches");
        do_ack(20); step(1);
        expect_sel(10'd1023, 8'hFF, "R7 legacy level ack clears");
        do_eoi(20); step(1);
        expect_sel(10'd20, 8'h30, "R8 eoi refill");
        do_ack(20); step(1);
        irq_lines[20] = 1'b0; step(2);
        do_eoi(20); step(1);
        expect_sel(10'd1023, 8'hFF, "R8 eoi with low line");

        // Newer mode: level pending follows line
        mode_newer = 1'b1; step(1);
        irq_lines[20] = 1'b1; step(2);
        expect_sel(10'd20, 8'h30, "R6 level pending by line");
        expect_rd(3'd2, 8'h10, "R10 byte2 bit4");
        irq_lines[20] = 1'b0; step(2);
        expect_sel(10'd1023, 8'hFF, "R6 level not latched");
        expect_rd(3'd2, 8'h00, "R10 byte2 cleared");

        irq_lines[20] = 1'b1; step(2);
        do_ack(20); step(1);
        expect_sel(10'd20, 8'h30, "R7 newer level stays pending");
        do_eoi(20); step(1);
        expect_sel(10'd20, 8'h30, "R9 eoi line high");
        irq_lines[20] = 1'b0; step(2);
        expect_sel(10'd1023, 8'hFF, "R9 no eoi refill");

        // Newer mode edge interrupt
        cfg_wr(3'd2, 33, 8'h05);
        cfg_wr(3'd1, 33, 8'h01);
        cfg_wr(3'd0, 33, 8'h01);
        irq_lines[33] = 1'b1; step(2);
        expect_sel(10'd33, 8'h05, "R6 edge latch newer");
        expect_rd(3'd4, 8'h02, "R10 byte4 bit1");
        irq_lines[33] = 1'b0; step(2);
        expect_sel(10'd33, 8'h05, "R6 edge stays latched");
        do_ack(33); step(1);
        expect_sel(10'd1023, 8'hFF, "R7 newer edge ack");

        // Software set/clear of the latch
        cfg_wr(3'd2, 40, 8'h50);
        cfg_wr(3'd0, 40, 8'h01);
        cfg_wr(3'd3, 40, 8'h00); step(1);
        expect_sel(10'd40, 8'h50, "R12 software set");
        cfg_wr(3'd4, 40, 8'h00); step(1);
        expect_sel(10'd1023, 8'hFF, "R12 software clear");
        ack_valid = 1'b1; ack_id = 10'd40;
        cfg_wr(3'd3, 40, 8'h00);
        ack_valid = 1'b0; step(1);
        expect_sel(10'd40, 8'h50, "R12 set wins over ack");
        cfg_wr(3'd4, 40, 8'h00); step(1);
        expect_sel(10'd1023, 8'hFF, "R12 final clear");

        finish_run();
    end

endmodule